// File: doc/BRIEF.md
# Masked Receive Address Filter

This block decides, for each received frame, whether a wireless MAC should take it in and acknowledge it. It sees only the receiver address and a two-bit frame-class code. It compares these against configuration loaded through a 32-bit write-only register port. The configuration holds a 48-bit station address, a 48-bit compare mask, a 64-bit multicast hash table, an 8-bit frame-type enable set and a receive-off switch. The result, an accept flag qualified by a valid strobe, appears one clock after the address is offered.

Unicast matching looks only at the address bits that the mask selects. One station address can therefore answer for several virtual networks. For a set of network identifiers, the mask is the AND over all of them of NOT(station XOR identifier). A foreign address that happens to agree on the selected bits is also taken, and this is expected behaviour. Group addresses are folded to a 6-bit hash that indexes the multicast table. The all-ones broadcast address has its own enable.

Each register write takes effect for frames offered from the next clock onward. All state clears on reset. After reset nothing passes until software enables a frame type.

Top module: `rx_addr_filter`

## Requirements
- R1: After synchronous reset, accept_valid and accept are 0, and every configuration field is zero. With type enable 0, no frame is accepted.
- R2: accept_valid is 1 for exactly the cycle after each cycle with addr_valid = 1, and 0 otherwise. accept is 0 whenever accept_valid is 0.
- R3: A unicast frame (rx_addr[0] = 0) is accepted when type bit 0 is set and ((rx_addr XOR station) AND mask) is zero. Address bits whose mask bit is 0 are ignored.
- R4: With a station nibble 0001 and a mask nibble 0010 placed at rx_addr[11:8], the nibbles 0001, 0100, 1001 and 1101 are accepted and 0110 is rejected.
- R5: Selectors 0 and 2 write bits 31:0 of the station address and of the mask. Selectors 1 and 3 write bits 47:32 from cfg_wdata[15:0], and cfg_wdata[31:16] of those writes has no effect.
- R6: A group frame (rx_addr[0] = 1, not all ones) is accepted when type bit 1 is set and table bit h is 1. Here h is the XOR of the eight slices rx_addr[6k+5:6k]. Selector 4 writes table bits 31:0 and selector 5 writes bits 63:32. Selector 8 sets and selector 9 clears bit cfg_wdata[5:0], but only when cfg_wdata[31:6] is zero; otherwise the write is ignored.
- R7: The all-ones address is accepted when type bit 2 is set, whatever the multicast table holds. It never passes through the hash path.
- R8: Selector 6 stores only cfg_wdata[7:0] as the type enable. Type bit 5 (promiscuous) accepts every frame.
- R9: cfg_wdata[0] written at selector 7 turns reception off. While it is 1, accept is 0 for every frame. Writing 0 restores acceptance.
- R10: rx_class codes are 0 data, 1 control, 2 beacon and 3 other. Type bit 3 accepts every control-class frame, bit 4 every beacon-class frame and bit 6 every other-class frame, whatever the address.
- R11: Type bit 7 accepts every group frame that is not all ones, without consulting the multicast table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register selector |
| cfg_wdata | input | 32 | Configuration write data |
| addr_valid | input | 1 | rx_addr and rx_class are valid this cycle |
| rx_addr | input | 48 | Receiver address, first byte in bits 7:0 |
| rx_class | input | 2 | Frame class code |
| accept_valid | output | 1 | Decision strobe, one cycle after addr_valid |
| accept | output | 1 | Frame accepted |

## Verification
The configuration cannot be read back. A corrupted station, mask or table bit therefore shows up only as a wrong accept on the first frame whose address depends on that bit. That wrong accept appears one clock after the frame is offered. The bench places frames so that each probed bit decides the outcome alone. It flips single masked and unmasked bits, steps hash indices on both sides of the word boundary, and offers an out-of-range index after which it checks the entry again. A stuck receive-off or type bit shows as a wrong flag on the very next frame. A timing slip shows as a strobe in a cycle where none is expected.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_W   = 48;
    localparam int WORD_W   = 32;
    localparam int HI_W     = ADDR_W - WORD_W;
    localparam int HASH_W   = 6;
    localparam int MC_BITS  = 1 << HASH_W;
    localparam int MC_WORDS = MC_BITS / WORD_W;
    localparam int WBIT_W   = $clog2(WORD_W);
    localparam int SLICES   = ADDR_W / HASH_W;
    localparam int TYPE_W   = 8;
    localparam int SEL_W    = 4;
    localparam int CLS_W    = 2;

    // type-enable bit positions
    localparam int TB_UCAST  = 0;
    localparam int TB_MCAST  = 1;
    localparam int TB_BCAST  = 2;
    localparam int TB_CTRL   = 3;
    localparam int TB_BEACON = 4;
    localparam int TB_PROM   = 5;
    localparam int TB_OTHER  = 6;
    localparam int TB_ALLGRP = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_STA_LO  = 4'd0,
        SEL_STA_HI  = 4'd1,
        SEL_MASK_LO = 4'd2,
        SEL_MASK_HI = 4'd3,
        SEL_MC0     = 4'd4,
        SEL_MC1     = 4'd5,
        SEL_TYPE    = 4'd6,
        SEL_CTRL    = 4'd7,
        SEL_MC_SET  = 4'd8,
        SEL_MC_CLR  = 4'd9
    } cfg_sel_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_DATA   = 2'd0,
        CLS_CTRL   = 2'd1,
        CLS_BEACON = 2'd2,
        CLS_OTHER  = 2'd3
    } frm_class_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  sta;
        logic [ADDR_W-1:0]  mask;
        logic [MC_BITS-1:0] mcast;
        logic [TYPE_W-1:0]  ftype;
        logic               rx_off;
    } filt_cfg_t;

    typedef struct packed {
        logic ucast_hit;
        logic mcast_hit;
        logic bcast_hit;
        logic class_hit;
        logic promisc;
    } match_t;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output filt_cfg_t         cfg
);

    logic [ADDR_W-1:0]  sta_q;
    logic [ADDR_W-1:0]  mask_q;
    logic [TYPE_W-1:0]  ftype_q;
    logic               rx_off_q;
    logic [MC_BITS-1:0] mc_flat;

    // index writes are honoured only when nothing sits above the index field
    logic              idx_ok;
    logic [HASH_W-1:0] idx;
    logic              is_set;
    logic              is_clr;

    assign idx_ok = (cfg_wdata[WORD_W-1:HASH_W] == '0);
    assign idx    = cfg_wdata[HASH_W-1:0];
    assign is_set = cfg_we && (cfg_sel == SEL_MC_SET) && idx_ok;
    assign is_clr = cfg_we && (cfg_sel == SEL_MC_CLR) && idx_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            sta_q    <= '0;
            mask_q   <= '0;
            ftype_q  <= '0;
            rx_off_q <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_STA_LO:  sta_q[WORD_W-1:0]       <= cfg_wdata;
                SEL_STA_HI:  sta_q[ADDR_W-1:WORD_W]  <= cfg_wdata[HI_W-1:0];
                SEL_MASK_LO: mask_q[WORD_W-1:0]      <= cfg_wdata;
                SEL_MASK_HI: mask_q[ADDR_W-1:WORD_W] <= cfg_wdata[HI_W-1:0];
                SEL_TYPE:    ftype_q                 <= cfg_wdata[TYPE_W-1:0];
                SEL_CTRL:    rx_off_q                <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    // one storage word per multicast table slice
    for (genvar w = 0; w < MC_WORDS; w++) begin : g_mc_word
        logic [WORD_W-1:0] word_q;
        logic              word_sel;
        logic              idx_here;

        assign word_sel = cfg_we && (int'(cfg_sel) == int'(SEL_MC0) + w);
        assign idx_here = (int'(idx[HASH_W-1:WBIT_W]) == w);

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (word_sel) begin
                word_q <= cfg_wdata;
            end else if (is_set && idx_here) begin
                word_q[idx[WBIT_W-1:0]] <= 1'b1;
            end else if (is_clr && idx_here) begin
                word_q[idx[WBIT_W-1:0]] <= 1'b0;
            end
        end

        assign mc_flat[w*WORD_W +: WORD_W] = word_q;
    end

    always_comb begin
        cfg.sta    = sta_q;
        cfg.mask   = mask_q;
        cfg.mcast  = mc_flat;
        cfg.ftype  = ftype_q;
        cfg.rx_off = rx_off_q;
    end

endmodule

// File: rtl/rxf_mcast_hash.sv
module rxf_mcast_hash
    import rxf_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic [MC_BITS-1:0] table_bits,
    output logic [HASH_W-1:0]  hash_idx,
    output logic               table_hit
);

    logic [HASH_W-1:0] fold [SLICES+1];

    assign fold[0] = '0;

    for (genvar s = 0; s < SLICES; s++) begin : g_fold
        assign fold[s+1] = fold[s] ^ addr[s*HASH_W +: HASH_W];
    end

    assign hash_idx  = fold[SLICES];
    assign table_hit = table_bits[hash_idx];

endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
(
    input  filt_cfg_t         cfg,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [CLS_W-1:0]  rx_class,
    input  logic              table_hit,
    output match_t            hits
);

    logic is_group;
    logic is_bcast;
    logic masked_eq;

    assign is_group  = rx_addr[0];
    assign is_bcast  = &rx_addr;
    assign masked_eq = (((rx_addr ^ cfg.sta) & cfg.mask) == '0);

    always_comb begin
        hits.ucast_hit = !is_group && masked_eq && cfg.ftype[TB_UCAST];
        hits.mcast_hit = is_group && !is_bcast &&
                         ((table_hit && cfg.ftype[TB_MCAST]) || cfg.ftype[TB_ALLGRP]);
        hits.bcast_hit = is_bcast && cfg.ftype[TB_BCAST];
        case (rx_class)
            CLS_CTRL:   hits.class_hit = cfg.ftype[TB_CTRL];
            CLS_BEACON: hits.class_hit = cfg.ftype[TB_BEACON];
            CLS_OTHER:  hits.class_hit = cfg.ftype[TB_OTHER];
            default:    hits.class_hit = 1'b0;
        endcase
        hits.promisc = cfg.ftype[TB_PROM];
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [rxf_pkg::SEL_W-1:0]  cfg_sel,
    input  logic [rxf_pkg::WORD_W-1:0] cfg_wdata,
    input  logic                      addr_valid,
    input  logic [rxf_pkg::ADDR_W-1:0] rx_addr,
    input  logic [rxf_pkg::CLS_W-1:0]  rx_class,
    output logic                      accept_valid,
    output logic                      accept
);

    filt_cfg_t         cfg;
    match_t            hits;
    logic [HASH_W-1:0] hash_idx;
    logic              table_hit;
    logic              any_hit;
    logic              rx_off_w;
    logic [TYPE_W-1:0] ftype_w;

    rxf_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    rxf_mcast_hash u_hash (
        .addr       (rx_addr),
        .table_bits (cfg.mcast),
        .hash_idx   (hash_idx),
        .table_hit  (table_hit)
    );

    rxf_match u_match (
        .cfg       (cfg),
        .rx_addr   (rx_addr),
        .rx_class  (rx_class),
        .table_hit (table_hit),
        .hits      (hits)
    );

    assign any_hit  = |hits;
    assign rx_off_w = cfg.rx_off;
    assign ftype_w  = cfg.ftype;

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_valid <= 1'b0;
            accept       <= 1'b0;
        end else begin
            accept_valid <= addr_valid;
            accept       <= addr_valid && !cfg.rx_off && any_hit;
        end
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] rx_addr,
    input logic              accept_valid,
    input logic              accept,
    input logic              rx_off,
    input logic [TYPE_W-1:0] ftype
);

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> accept_valid);                                   // R2

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |=> !accept_valid);                                 // R2

    AST_NO_STRAY_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        !accept_valid |-> !accept);                                     // R2

    AST_RX_OFF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && rx_off) |=> !accept);                            // R9

    AST_PROMISC_PASSES: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !rx_off && ftype[TB_PROM]) |=> accept);          // R8

    AST_BCAST_PASSES: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !rx_off && ftype[TB_BCAST] && (&rx_addr)) |=> accept); // R7

endmodule

bind rx_addr_filter rxf_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr_valid   (addr_valid),
    .rx_addr      (rx_addr),
    .accept_valid (accept_valid),
    .accept       (accept),
    .rx_off       (rx_off_w),
    .ftype        (ftype_w)
);

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        addr_valid = 1'b0;
    logic [47:0] rx_addr = '0;
    logic [1:0]  rx_class = '0;
    logic        accept_valid;
    logic        accept;

    always #4 clk = ~clk;

    rx_addr_filter u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .addr_valid   (addr_valid),
        .rx_addr      (rx_addr),
        .rx_class     (rx_class),
        .accept_valid (accept_valid),
        .accept       (accept)
    );

    typedef struct {
        logic        exp;
        string       tag;
        logic [47:0] a;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    localparam logic [47:0] STA   = 48'h3C4D_5E6F_7A10;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] GRP_A = 48'h0000_0000_0001; // hash 1
    localparam logic [47:0] GRP_B = 48'h0000_0000_0029; // hash 41
    localparam logic [47:0] GRP_C = 48'hF0E1_D2C3_B4A5;
    localparam logic [47:0] XBASE = 48'h1234_5678_0000;
    localparam logic [47:0] FOREIGN = 48'h1111_2222_3330;

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int k = 0; k < 8; k++) h ^= a[k*6 +: 6];
        return h;
    endfunction

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [47:0] a, input logic [1:0] c,
                        input logic e, input string tag);
        exp_t it;
        @(negedge clk);
        addr_valid = 1'b1; rx_addr = a; rx_class = c;
        @(posedge clk);
        #1;
        it.exp = e; it.tag = tag; it.a = a;
        sb.push_back(it);
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t it;
        if (!rst) begin
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (accept_valid !== 1'b1 || accept !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr=%h: got valid=%b accept=%b, expected valid=1 accept=%b",
                             it.tag, it.a, accept_valid, accept, it.exp);
                end
            end else if (accept_valid !== 1'b0) begin
                checks++;
                fails++;
                $display("FAIL R2 stray strobe: got accept_valid=%b, expected 0", accept_valid);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2: got no completion, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (accept_valid !== 1'b0 || accept !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: got %b%b, expected 00", accept_valid, accept);
        end
        rst = 1'b0;

        // R1: nothing passes from reset state
        send(48'h0, 2'd0, 1'b0, "R1 zero addr after reset");
        send(BCAST, 2'd0, 1'b0, "R1 broadcast after reset");
        send(48'h0, 2'd1, 1'b0, "R1 control after reset");

        // R3 / R5: full-mask unicast, junk in upper halves of high writes
        wr(4'd0, STA[31:0]);
        wr(4'd1, {16'hDEAD, STA[47:32]});
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd6, 32'h0000_0001);
        send(STA, 2'd0, 1'b1, "R5 R3 exact station");
        send(STA ^ (48'h1 << 40), 2'd0, 1'b0, "R3 bit40 differs");
        send(STA ^ (48'h1 << 20), 2'd0, 1'b0, "R3 bit20 differs");
        wr(4'd3, 32'h0000_FF00);
        send(STA ^ (48'h1 << 33), 2'd0, 1'b1, "R3 unmasked bit33 ignored");
        send(STA ^ (48'h1 << 40), 2'd0, 1'b0, "R3 masked bit40 still compared");
        send(STA, 2'd1, 1'b1, "R3 class has no effect on unicast hit");

        // R4: four-bit example at rx_addr[11:8]
        wr(4'd0, 32'h0000_0100);
        wr(4'd1, 32'hFFFF_0000);
        wr(4'd2, 32'h0000_0200);
        wr(4'd3, 32'h0000_0000);
        send(XBASE | 48'h100, 2'd0, 1'b1, "R4 nibble 0001");
        send(XBASE | 48'h400, 2'd0, 1'b1, "R4 nibble 0100");
        send(XBASE | 48'h900, 2'd0, 1'b1, "R4 nibble 1001");
        send(XBASE | 48'hD00, 2'd0, 1'b1, "R4 nibble 1101 false accept");
        send(XBASE | 48'h600, 2'd0, 1'b0, "R4 nibble 0110 rejected");

        // R6: multicast hash table
        wr(4'd6, 32'h0000_0002);
        send(GRP_A, 2'd0, 1'b0, "R6 empty table");
        wr(4'd8, 32'd1);
        send(GRP_A, 2'd0, 1'b1, "R6 set index 1");
        send(GRP_B, 2'd0, 1'b0, "R6 index 41 still clear");
        wr(4'd8, 32'd41);
        send(GRP_B, 2'd0, 1'b1, "R6 set index 41 (upper word)");
        wr(4'd5, 32'h0000_0000);
        send(GRP_B, 2'd0, 1'b0, "R6 upper word cleared");
        wr(4'd5, 32'h0000_0200);
        send(GRP_B, 2'd0, 1'b1, "R6 upper word bit9 = index 41");
        wr(4'd9, 32'd105);
        send(GRP_B, 2'd0, 1'b1, "R6 clear index 105 ignored");
        wr(4'd9, 32'd41);
        send(GRP_B, 2'd0, 1'b0, "R6 clear index 41");
        wr(4'd9, 32'd1);
        wr(4'd8, 32'd65);
        send(GRP_A, 2'd0, 1'b0, "R6 set index 65 ignored");
        wr(4'd8, {26'd0, hidx(GRP_C)});
        send(GRP_C, 2'd0, 1'b1, "R6 folded hash of mixed address");
        wr(4'd4, 32'h0000_0000);
        wr(4'd5, 32'h0000_0000);
        send(GRP_C, 2'd0, 1'b0, "R6 words cleared");

        // R7: broadcast
        send(BCAST, 2'd0, 1'b0, "R7 broadcast without its enable");
        wr(4'd6, 32'h0000_0004);
        send(BCAST, 2'd0, 1'b1, "R7 broadcast enabled, empty table");
        send(STA, 2'd0, 1'b0, "R7 unicast disabled");

        // R11: all-group enable
        wr(4'd6, 32'h0000_0080);
        send(GRP_A, 2'd0, 1'b1, "R11 group without table");
        send(XBASE | 48'h100, 2'd0, 1'b0, "R11 unicast not affected");
        send(BCAST, 2'd0, 1'b0, "R11 broadcast not included");

        // R10: class enables
        wr(4'd6, 32'h0000_0008);
        send(FOREIGN, 2'd1, 1'b1, "R10 control class");
        send(FOREIGN, 2'd0, 1'b0, "R10 data class");
        send(FOREIGN, 2'd2, 1'b0, "R10 beacon without enable");
        wr(4'd6, 32'h0000_0010);
        send(FOREIGN, 2'd2, 1'b1, "R10 beacon class");
        wr(4'd6, 32'h0000_0040);
        send(FOREIGN, 2'd3, 1'b1, "R10 other class");
        send(FOREIGN, 2'd1, 1'b0, "R10 control without enable");

        // R8: promiscuous and stored width
        wr(4'd6, 32'hFFFF_FF20);
        send(FOREIGN, 2'd0, 1'b1, "R8 promiscuous unicast");
        send(GRP_A, 2'd0, 1'b1, "R8 promiscuous group");
        wr(4'd6, 32'h0000_0100);
        send(BCAST, 2'd0, 1'b0, "R8 bit8 not stored");
        send(FOREIGN, 2'd1, 1'b0, "R8 type cleared");

        // R9: receive off
        wr(4'd6, 32'h0000_0020);
        wr(4'd7, 32'h0000_0001);
        send(FOREIGN, 2'd0, 1'b0, "R9 receive off");
        send(BCAST, 2'd1, 1'b0, "R9 receive off, any class");
        wr(4'd7, 32'h0000_0000);
        send(FOREIGN, 2'd0, 1'b1, "R9 receive back on");

        // R2: back-to-back idle spacing then drain
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2 pending decisions: got %0d, expected 0", sb.size());
        end

        done = 1;
        summary();
        $finish;
    end

endmodule